// File: doc/BRIEF.md
# Ternary Gate Stream Peephole Reducer

This block sits in a stream of ternary reversible gate descriptors and shortens it without changing its overall function. Each descriptor names a control line, a target line and one of six permutations of the trit values {0,1,2}. When two consecutive descriptors act on the same target through the same control arrangement, the block replaces them with one descriptor whose permutation is the first one followed by the second. If that composition is the identity, both descriptors disappear.

A descriptor is uncontrolled when its control index equals its target index. Two uncontrolled descriptors merge when they share the target line. Two controlled descriptors merge only when both the control and the target line match. A controlled and an uncontrolled descriptor never merge.

The block keeps one pending descriptor. Input and output use valid/ready handshakes, and the output is a register. A flush request forces the pending descriptor out at the end of a stream. An output counter reports how many descriptors have left the block.

Top module: `tgr_peephole`

## Requirements
- R1: After a synchronous reset, out_valid is 0, out_count is 0, and in_ready is 1 while flush is low.
- R2: Type codes are 0 identity, 1 x+1 mod 3, 2 x+2 mod 3, 3 swap of 0 and 1, 4 swap of 0 and 2, and 5 swap of 1 and 2. Codes 6 and 7 are treated as identity. An identity descriptor that cannot merge is dropped and is never emitted.
- R3: Two consecutive uncontrolled descriptors (control equal to target) on the same line merge into one. The merged descriptor applies the first permutation and then the second.
- R4: Two consecutive controlled descriptors merge only when both control and target match. A change of control line, or a mix of controlled and uncontrolled descriptors on one target, gives separate outputs.
- R5: When a merge composes to the identity, no descriptor is pending afterwards, and neither input produces an output.
- R6: An accepted descriptor that cannot merge with the pending one pushes the pending one into the output register, which is valid in the next cycle. The new descriptor then becomes pending. Apart from a flush, this is the only way a descriptor is emitted.
- R7: While flush is high, in_ready is 0. The pending descriptor, if any, is moved to the output register at the first cycle in which the output register is free.
- R8: While out_valid is 1 and out_ready is 0, the output fields hold steady. in_ready equals (not out_valid, or out_ready) while flush is low.
- R9: out_count rises by exactly one for each completed output handshake and is otherwise unchanged.
- R10: An emitted descriptor never carries an identity type. out_type is always in the range 1 to 5 when out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Input descriptor accepted when high with in_valid |
| in_ctrl | input | LINE_W | Control line index |
| in_tgt | input | LINE_W | Target line index |
| in_type | input | 3 | Permutation code |
| flush | input | 1 | End-of-stream request, held high for as long as needed |
| out_valid | output | 1 | Output descriptor valid |
| out_ready | input | 1 | Downstream accepts the output descriptor |
| out_ctrl | output | LINE_W | Emitted control line index |
| out_tgt | output | LINE_W | Emitted target line index |
| out_type | output | 3 | Emitted permutation code |
| out_count | output | COUNT_W | Number of descriptors handed downstream |

## Verification
A corrupted pending descriptor cannot be seen until the next non-mergeable input or flush, so the bench ends every directed scenario with a flush and checks the result in the following cycle. A wrong composition entry shows up as a wrong out_type one cycle after the merging pair is closed. A lost pending-valid bit shows up as a missing output and an out_count that stays behind. The reference model is compared against every output and against in_ready on every clock, including while randomly chosen out_ready stalls are applied, so a fault in the hold or count logic is reported within a cycle.

// File: rtl/tgr_pkg.sv
package tgr_pkg;
  typedef logic [1:0] trit_t;

  typedef enum logic [2:0] {
    OP_ID   = 3'd0,
    OP_INC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_SW01 = 3'd3,
    OP_SW02 = 3'd4,
    OP_SW12 = 3'd5
  } gate_op_e;

  // Unused codes collapse to identity.
  function automatic gate_op_e norm_op(input logic [2:0] raw);
    if (raw > 3'd5) return OP_ID;
    return gate_op_e'(raw);
  endfunction

  function automatic trit_t perm_apply(input gate_op_e op, input trit_t x);
    trit_t r;
    case (op)
      OP_INC:  r = (x == 2'd2) ? 2'd0 : x + 2'd1;
      OP_DEC:  r = (x == 2'd0) ? 2'd2 : x - 2'd1;
      OP_SW01: r = (x == 2'd0) ? 2'd1 : (x == 2'd1) ? 2'd0 : x;
      OP_SW02: r = (x == 2'd0) ? 2'd2 : (x == 2'd2) ? 2'd0 : x;
      OP_SW12: r = (x == 2'd1) ? 2'd2 : (x == 2'd2) ? 2'd1 : x;
      default: r = x;
    endcase
    return r;
  endfunction

  // Recover the permutation code from the images of 0, 1 and 2.
  function automatic gate_op_e perm_code(input trit_t i0, input trit_t i1, input trit_t i2);
    gate_op_e r;
    case ({i0, i1, i2})
      6'b01_10_00: r = OP_INC;
      6'b10_00_01: r = OP_DEC;
      6'b01_00_10: r = OP_SW01;
      6'b10_01_00: r = OP_SW02;
      6'b00_10_01: r = OP_SW12;
      default:     r = OP_ID;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tgr_compose.sv
module tgr_compose
  import tgr_pkg::*;
#(
  parameter int NUM_VALS = 3
) (
  input  gate_op_e first_op,
  input  gate_op_e second_op,
  output gate_op_e joint_op
);
  trit_t img [NUM_VALS];

  for (genvar v = 0; v < NUM_VALS; v++) begin : g_img
    assign img[v] = perm_apply(second_op, perm_apply(first_op, trit_t'(v)));
  end

  assign joint_op = perm_code(img[0], img[1], img[2]);
endmodule

// File: rtl/tgr_merge_ctl.sv
module tgr_merge_ctl #(
  parameter int LINE_W = 2
) (
  input  logic              pend_v,
  input  logic [LINE_W-1:0] pend_ctrl,
  input  logic [LINE_W-1:0] pend_tgt,
  input  logic [LINE_W-1:0] new_ctrl,
  input  logic [LINE_W-1:0] new_tgt,
  output logic              can_merge
);
  logic pend_unctl, new_unctl, same_kind, same_lines;

  assign pend_unctl = (pend_ctrl == pend_tgt);
  assign new_unctl  = (new_ctrl == new_tgt);
  assign same_kind  = (pend_unctl == new_unctl);
  // Uncontrolled pairs need only the target; controlled pairs need both lines.
  assign same_lines = (pend_tgt == new_tgt) && (pend_unctl || (pend_ctrl == new_ctrl));
  assign can_merge  = pend_v && same_kind && same_lines;
endmodule

// File: rtl/tgr_out_stage.sv
module tgr_out_stage
  import tgr_pkg::*;
#(
  parameter int LINE_W  = 2,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [LINE_W-1:0]  ld_ctrl,
  input  logic [LINE_W-1:0]  ld_tgt,
  input  gate_op_e           ld_op,
  input  logic               out_ready,
  output logic               slot_free,
  output logic               out_valid,
  output logic [LINE_W-1:0]  out_ctrl,
  output logic [LINE_W-1:0]  out_tgt,
  output logic [2:0]         out_type,
  output logic [COUNT_W-1:0] out_count
);
  logic taken;

  assign taken     = out_valid && out_ready;
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ctrl  <= '0;
      out_tgt   <= '0;
      out_type  <= '0;
      out_count <= '0;
    end else begin
      if (taken) out_count <= out_count + 1'b1;
      if (load) begin
        out_valid <= 1'b1;
        out_ctrl  <= ld_ctrl;
        out_tgt   <= ld_tgt;
        out_type  <= ld_op;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tgr_peephole.sv
module tgr_peephole
  import tgr_pkg::*;
#(
  parameter int LINE_W  = 2,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LINE_W-1:0]  in_ctrl,
  input  logic [LINE_W-1:0]  in_tgt,
  input  logic [2:0]         in_type,
  input  logic               flush,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LINE_W-1:0]  out_ctrl,
  output logic [LINE_W-1:0]  out_tgt,
  output logic [2:0]         out_type,
  output logic [COUNT_W-1:0] out_count
);
  logic              pend_v, pend_v_n;
  logic [LINE_W-1:0] pend_ctrl, pend_ctrl_n, pend_tgt, pend_tgt_n;
  gate_op_e          pend_op, pend_op_n, new_op, joint_op;
  logic              slot_free, accept, can_merge, emit;

  assign new_op   = norm_op(in_type);
  assign in_ready = slot_free && !flush;
  assign accept   = in_valid && in_ready;

  tgr_merge_ctl #(.LINE_W(LINE_W)) merge_i (
    .pend_v(pend_v), .pend_ctrl(pend_ctrl), .pend_tgt(pend_tgt),
    .new_ctrl(in_ctrl), .new_tgt(in_tgt), .can_merge(can_merge)
  );

  tgr_compose compose_i (
    .first_op(pend_op), .second_op(new_op), .joint_op(joint_op)
  );

  always_comb begin
    emit        = 1'b0;
    pend_v_n    = pend_v;
    pend_ctrl_n = pend_ctrl;
    pend_tgt_n  = pend_tgt;
    pend_op_n   = pend_op;
    if (accept) begin
      if (can_merge) begin
        pend_op_n = joint_op;
        pend_v_n  = (joint_op != OP_ID);
      end else begin
        emit        = pend_v;
        pend_ctrl_n = in_ctrl;
        pend_tgt_n  = in_tgt;
        pend_op_n   = new_op;
        pend_v_n    = (new_op != OP_ID);
      end
    end else if (flush && slot_free && pend_v) begin
      emit     = 1'b1;
      pend_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_ctrl <= '0;
      pend_tgt  <= '0;
      pend_op   <= OP_ID;
    end else begin
      pend_v    <= pend_v_n;
      pend_ctrl <= pend_ctrl_n;
      pend_tgt  <= pend_tgt_n;
      pend_op   <= pend_op_n;
    end
  end

  tgr_out_stage #(.LINE_W(LINE_W), .COUNT_W(COUNT_W)) out_i (
    .clk(clk), .rst(rst), .load(emit),
    .ld_ctrl(pend_ctrl), .ld_tgt(pend_tgt), .ld_op(pend_op),
    .out_ready(out_ready), .slot_free(slot_free),
    .out_valid(out_valid), .out_ctrl(out_ctrl), .out_tgt(out_tgt),
    .out_type(out_type), .out_count(out_count)
  );
endmodule

// File: rtl/tgr_peephole_chk.sv
module tgr_peephole_chk #(
  parameter int LINE_W  = 2,
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               flush,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LINE_W-1:0]  out_ctrl,
  input logic [LINE_W-1:0]  out_tgt,
  input logic [2:0]         out_type,
  input logic [COUNT_W-1:0] out_count
);
  logic prev_rst = 1'b0;
  always_ff @(posedge clk) prev_rst <= rst;

  assert_reset_state_R1: assert property (@(posedge clk)
    prev_rst |-> (!out_valid && out_count == '0));

  assert_emit_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past((in_valid && in_ready) || flush));

  assert_flush_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ctrl) && $stable(out_tgt) && $stable(out_type)));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (out_count == $past(out_count) + 1'b1));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_ready) |=> $stable(out_count));

  assert_no_identity_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_type >= 3'd1 && out_type <= 3'd5));
endmodule

bind tgr_peephole tgr_peephole_chk #(.LINE_W(LINE_W), .COUNT_W(COUNT_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .flush(flush),
  .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl),
  .out_tgt(out_tgt), .out_type(out_type), .out_count(out_count)
);

// File: tb/tgr_peephole_tb.sv
module tgr_peephole_tb_top;
  localparam int LINE_W  = 2;
  localparam int COUNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, flush = 1'b0, out_ready = 1'b1;
  logic [LINE_W-1:0] in_ctrl = '0, in_tgt = '0;
  logic [2:0] in_type = '0;
  logic in_ready, out_valid;
  logic [LINE_W-1:0] out_ctrl, out_tgt;
  logic [2:0] out_type;
  logic [COUNT_W-1:0] out_count;

  always #4 clk = ~clk;

  tgr_peephole #(.LINE_W(LINE_W), .COUNT_W(COUNT_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctrl(in_ctrl), .in_tgt(in_tgt), .in_type(in_type), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl),
    .out_tgt(out_tgt), .out_type(out_type), .out_count(out_count)
  );

  int checks = 0, errors = 0, cycles = 0;
  string phase_req = "R1";
  bit stall_mode = 0;
  int last_type = -1;
  bit done = 0;

  // Behavioural reference state.
  bit m_pv = 0, m_ov = 0;
  int m_pc = 0, m_pt = 0, m_pop = 0;
  int m_oc = 0, m_ot = 0, m_oop = 0, m_cnt = 0;

  function automatic int tmap(int op, int x);
    case (op)
      1: return (x + 1) % 3;
      2: return (x + 2) % 3;
      3: return (2 * x + 1) % 3;
      4: return (2 * x + 2) % 3;
      5: return (2 * x) % 3;
      default: return x;
    endcase
  endfunction

  function automatic int tjoin(int a, int b);
    for (int c = 0; c < 6; c++) begin
      bit ok = 1;
      for (int x = 0; x < 3; x++)
        if (tmap(c, x) != tmap(b, tmap(a, x))) ok = 0;
      if (ok) return c;
    end
    return 0;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_pv = 0; m_ov = 0; m_cnt = 0;
    end else begin
      bit free, rdy, ld;
      int nop, ct, tg;
      free = !m_ov || out_ready;
      rdy  = free && !flush;
      ld   = 0;
      if (m_ov && out_ready) m_cnt = (m_cnt + 1) % (1 << COUNT_W);
      if (in_valid && rdy) begin
        nop = (in_type > 5) ? 0 : int'(in_type);
        ct = int'(in_ctrl); tg = int'(in_tgt);
        if (m_pv && ((m_pc == m_pt) == (ct == tg)) && m_pt == tg && (ct == tg || m_pc == ct)) begin
          m_pop = tjoin(m_pop, nop);
          m_pv  = (m_pop != 0);
        end else begin
          if (m_pv) begin ld = 1; m_oc = m_pc; m_ot = m_pt; m_oop = m_pop; end
          m_pc = ct; m_pt = tg; m_pop = nop; m_pv = (nop != 0);
        end
      end else if (flush && free && m_pv) begin
        ld = 1; m_oc = m_pc; m_ot = m_pt; m_oop = m_pop; m_pv = 0;
      end
      if (ld) m_ov = 1;
      else if (out_ready) m_ov = 0;
    end
  end

  // Downstream ready and per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (stall_mode) out_ready = ($urandom_range(0, 3) != 0);
    else out_ready = 1'b1;
    #2;
    if (!rst && !done) begin
      check(phase_req, int'(in_ready), int'((!m_ov || out_ready) && !flush), "in_ready");
      check(phase_req, int'(out_valid), int'(m_ov), "out_valid");
      check(phase_req, int'(out_count), m_cnt, "out_count");
      if (m_ov) begin
        check(phase_req, int'(out_ctrl), m_oc, "out_ctrl");
        check(phase_req, int'(out_tgt), m_ot, "out_tgt");
        check(phase_req, int'(out_type), m_oop, "out_type");
        if (out_ready) last_type = int'(out_type);
      end
    end
  end

  task automatic send(int c, int t, int ty);
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = LINE_W'(c); in_tgt = LINE_W'(t); in_type = 3'(ty);
    #3;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    repeat (3) @(negedge clk);
    flush = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  int base;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #3;
    check("R1", int'(out_valid), 0, "out_valid after reset");
    check("R1", int'(out_count), 0, "out_count after reset");
    check("R1", int'(in_ready), 1, "in_ready after reset");

    phase_req = "R3";
    base = int'(out_count);
    send(0, 0, 1); send(0, 0, 1); do_flush();
    check("R3", last_type, 2, "inc then inc gives dec");
    check("R3", int'(out_count) - base, 1, "one gate left");
    send(1, 1, 3); send(1, 1, 1); do_flush();
    check("R3", last_type, 4, "swap01 then inc gives swap02");

    phase_req = "R5";
    base = int'(out_count);
    send(2, 2, 5); send(2, 2, 5); do_flush();
    send(3, 3, 1); send(3, 3, 2); do_flush();
    check("R5", int'(out_count) - base, 0, "cancelling pairs vanish");

    phase_req = "R4";
    base = int'(out_count);
    send(0, 1, 1); send(0, 1, 1); do_flush();
    check("R4", last_type, 2, "controlled pair merged");
    check("R4", int'(out_count) - base, 1, "controlled pair one gate");
    base = int'(out_count);
    send(2, 1, 1); send(3, 1, 1); do_flush();
    check("R4", int'(out_count) - base, 2, "different control kept apart");
    base = int'(out_count);
    send(1, 1, 1); send(0, 1, 1); do_flush();
    check("R4", int'(out_count) - base, 2, "mixed kinds kept apart");

    phase_req = "R2";
    base = int'(out_count);
    send(0, 0, 6); send(1, 1, 7); send(2, 2, 0); do_flush();
    check("R2", int'(out_count) - base, 0, "identity codes dropped");

    phase_req = "R6";
    base = int'(out_count);
    send(0, 0, 1); send(1, 1, 2);
    repeat (2) @(negedge clk);
    check("R6", int'(out_count) - base, 1, "pending pushed out by new gate");
    check("R6", last_type, 1, "pushed gate type");
    do_flush();
    check("R7", int'(out_count) - base, 2, "flush drains pending");

    phase_req = "R8";
    stall_mode = 1;
    for (int i = 0; i < 400; i++) begin
      send($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) do_flush();
    end
    phase_req = "R7";
    do_flush();
    stall_mode = 0;
    phase_req = "R9";
    repeat (6) @(negedge clk);
    check("R10", int'(out_valid), 0, "stream drained");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule